// File: doc/BRIEF.md
# Endian-Switchable 32-bit Register Bank on a 64-bit Bus

This block is a bank of 32-bit control registers that a processor reaches through a 64-bit data bus. A static mode input sets how byte lanes on the bus are numbered. In little-endian mode lane 0 is the least significant byte of the bus. In big-endian mode lane 0 is the most significant byte. The byte offset of an access inside its 8-byte-aligned block is the number of the lane it uses. Register n sits at byte address 4n.

Full-word loads and stores must see the same register value in both modes. The block achieves this by exchanging only the two 32-bit halves of the bus when the mode changes. Bytes are never reordered inside a word. As a result, byte, half-word and double-word accesses see a layout that depends on the mode. Writes merge into the registers byte by byte under the byte enables. Reads return data on a registered path with a one-cycle ready pulse.

Access size encoding on `size_i`: 0 = 8 bit, 1 = 16 bit, 2 = 32 bit, 3 = 64 bit.

Top module: `endian_reg_bank`

## Requirements
- R1: While reset is asserted, and after it, every register reads zero, `ready_o` is low and `rdata_o` is zero.
- R2: A 32-bit write followed by a 32-bit read of the same register returns the same 32-bit value in both modes, including when the mode changed between the write and the read.
- R3: Lane k occupies data bits 8k+7:8k in little-endian mode and bits 63-8k:56-8k in big-endian mode. In both modes the lane number equals `addr_i[2:0]`.
- R4: For the register pair in one 8-byte block, the register at the lower word address sits on bits 31:0 in little-endian mode and on bits 63:32 in big-endian mode. Each register keeps its own bit order in both placements. A 64-bit access at an 8-byte-aligned address reads or writes both registers of the pair.
- R5: A byte read at offset 0 returns register bits 7:0 in little-endian mode and bits 31:24 in big-endian mode, on the data bits of lane 0. A 16-bit read at offset 2 returns register bits 31:16 in little-endian mode and bits 15:0 in big-endian mode.
- R6: A write changes only those register bytes whose lane is inside the access window (offset through offset plus size minus one) and whose `be_i` bit (indexed by lane number) is set. All other bytes keep their value. Cycles without a write request change no register.
- R7: `ready_o` is high for exactly the cycle after each cycle with `req_i` high, and low otherwise. Read data is valid in that same cycle. Back-to-back requests are accepted in every cycle.
- R8: An access whose offset is not a multiple of its size writes nothing and returns zero data. It still gets its ready pulse.
- R9: `rdata_o` is zero for lanes outside the read window, on the response to a write, and in idle cycles. `be_i` has no effect on reads.
- R10: The mode may change only while no transfer is outstanding. The first request after a change uses the new lane numbering.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| big_endian_i | input | 1 | Lane numbering mode: 1 = big-endian, 0 = little-endian |
| req_i | input | 1 | Access request, one cycle per transfer |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W (5) | Byte address |
| size_i | input | 2 | Access size code (0:8, 1:16, 2:32, 3:64 bit) |
| be_i | input | BUS_W/8 (8) | Write byte enables, bit k for lane k |
| wdata_i | input | BUS_W (64) | Write data |
| rdata_o | output | BUS_W (64) | Registered read data |
| ready_o | output | 1 | One-cycle response pulse |

## Verification
A wrong lane-to-register mapping or a stray intra-word swap shows at the ports on the first read after the faulty write. That read returns a value with misplaced or permuted bytes exactly one cycle after it is requested. A corrupted byte-merge state stays hidden until that register is read, so the bench reads back every written pattern under both modes. It also compares `ready_o` and `rdata_o` against a byte-addressed model on every clock, so a wrong response surfaces in the cycle it occurs.

// File: rtl/erb_pkg.sv
package erb_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE  = 2'd0,
    SZ_HALF  = 2'd1,
    SZ_WORD  = 2'd2,
    SZ_DWORD = 2'd3
  } acc_size_e;
endpackage

// File: rtl/erb_lane_decode.sv
// Decodes offset and size into a lane window, then maps lane numbers to
// physical byte positions according to the endian mode.
module erb_lane_decode
  import erb_pkg::*;
#(
  parameter int BUS_BYTES = 8,
  localparam int OFF_W    = $clog2(BUS_BYTES)
) (
  input  logic [OFF_W-1:0]     off_i,
  input  acc_size_e            size_i,
  input  logic [BUS_BYTES-1:0] be_i,
  input  logic                 big_i,
  output logic                 aligned_o,
  output logic [BUS_BYTES-1:0] win_phys_o,
  output logic [BUS_BYTES-1:0] wr_phys_o
);
  logic [OFF_W:0]         nbytes;
  logic [OFF_W:0]         off_ext;
  logic [BUS_BYTES-1:0]   lane_win;
  logic [BUS_BYTES-1:0]   lane_wr;

  always_comb begin
    case (size_i)
      SZ_BYTE:  nbytes = (OFF_W+1)'(1);
      SZ_HALF:  nbytes = (OFF_W+1)'(2);
      SZ_WORD:  nbytes = (OFF_W+1)'(4);
      SZ_DWORD: nbytes = (OFF_W+1)'(8);
    endcase
    off_ext   = {1'b0, off_i};
    aligned_o = ((off_ext & (nbytes - 1'b1)) == '0);
  end

  for (genvar k = 0; k < BUS_BYTES; k++) begin : g_lane
    assign lane_win[k] = ((OFF_W+1)'(k) >= off_ext) &&
                         ((OFF_W+2)'(k) < ({1'b0, off_ext} + {1'b0, nbytes}));
    assign lane_wr[k]  = lane_win[k] & be_i[k];
  end

  for (genvar p = 0; p < BUS_BYTES; p++) begin : g_phys
    assign win_phys_o[p] = big_i ? lane_win[BUS_BYTES-1-p] : lane_win[p];
    assign wr_phys_o[p]  = big_i ? lane_wr[BUS_BYTES-1-p]  : lane_wr[p];
  end
endmodule

// File: rtl/erb_reg_file.sv
// Register storage. Physical bus words are exchanged with the mode; the
// bytes inside a word keep their position.
module erb_reg_file #(
  parameter int NUM_REGS = 8,
  parameter int REG_W    = 32,
  parameter int BUS_W    = 64,
  localparam int WB        = REG_W / 8,
  localparam int WPB       = BUS_W / REG_W,
  localparam int BUS_BYTES = BUS_W / 8,
  localparam int BLK_W     = $clog2(NUM_REGS / WPB)
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           wr_en_i,
  input  logic [BLK_W-1:0]               blk_i,
  input  logic                           big_i,
  input  logic [BUS_BYTES-1:0]           mask_i,
  input  logic [BUS_W-1:0]               wdata_i,
  output logic [NUM_REGS-1:0][REG_W-1:0] regs_o
);
  logic [NUM_REGS-1:0][REG_W-1:0] regs_q;
  logic [NUM_REGS-1:0][REG_W-1:0] regs_d;

  always_comb begin
    regs_d = regs_q;
    for (int r = 0; r < NUM_REGS; r++) begin
      int slot;
      int w;
      slot = r % WPB;
      w    = big_i ? (WPB - 1 - slot) : slot;
      if (blk_i == BLK_W'(r / WPB)) begin
        for (int b = 0; b < WB; b++) begin
          if (mask_i[w*WB + b]) begin
            regs_d[r][b*8 +: 8] = wdata_i[(w*WB + b)*8 +: 8];
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      regs_q <= '0;
    end else if (wr_en_i) begin
      regs_q <= regs_d;
    end
  end

  assign regs_o = regs_q;
endmodule

// File: rtl/erb_read_steer.sv
// Places the register pair of the addressed block onto the bus halves and
// clears lanes outside the access window.
module erb_read_steer #(
  parameter int NUM_REGS = 8,
  parameter int REG_W    = 32,
  parameter int BUS_W    = 64,
  localparam int WPB       = BUS_W / REG_W,
  localparam int BUS_BYTES = BUS_W / 8,
  localparam int BLK_W     = $clog2(NUM_REGS / WPB),
  localparam int IDX_W     = $clog2(NUM_REGS)
) (
  input  logic [NUM_REGS-1:0][REG_W-1:0] regs_i,
  input  logic [BLK_W-1:0]               blk_i,
  input  logic                           big_i,
  input  logic [BUS_BYTES-1:0]           win_i,
  output logic [BUS_W-1:0]               rdata_o
);
  logic [WPB-1:0][REG_W-1:0] words;
  logic [BUS_W-1:0]          flat;

  always_comb begin
    for (int w = 0; w < WPB; w++) begin
      int slot;
      logic [IDX_W-1:0] idx;
      slot     = big_i ? (WPB - 1 - w) : w;
      idx      = IDX_W'(int'(blk_i) * WPB + slot);
      words[w] = regs_i[idx];
    end
  end

  assign flat = words;

  for (genvar p = 0; p < BUS_BYTES; p++) begin : g_mask
    assign rdata_o[p*8 +: 8] = win_i[p] ? flat[p*8 +: 8] : 8'h00;
  end
endmodule

// File: rtl/endian_reg_bank.sv
module endian_reg_bank
  import erb_pkg::*;
#(
  parameter int NUM_REGS = 8,
  parameter int REG_W    = 32,
  parameter int BUS_W    = 64,
  parameter int ADDR_W   = $clog2(NUM_REGS * REG_W / 8)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 big_endian_i,
  input  logic                 req_i,
  input  logic                 we_i,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic [1:0]           size_i,
  input  logic [BUS_W/8-1:0]   be_i,
  input  logic [BUS_W-1:0]     wdata_i,
  output logic [BUS_W-1:0]     rdata_o,
  output logic                 ready_o
);
  localparam int BUS_BYTES = BUS_W / 8;
  localparam int OFF_W     = $clog2(BUS_BYTES);
  localparam int WPB       = BUS_W / REG_W;
  localparam int BLK_W     = $clog2(NUM_REGS / WPB);

  acc_size_e                      size;
  logic                           aligned;
  logic [BUS_BYTES-1:0]           win_phys;
  logic [BUS_BYTES-1:0]           wr_phys;
  logic [BLK_W-1:0]               blk;
  logic                           wr_en;
  logic                           rd_hit;
  logic [NUM_REGS-1:0][REG_W-1:0] regs_q;
  logic [BUS_W-1:0]               steer_data;
  logic [BUS_W-1:0]               rdata_d;
  logic [BUS_W-1:0]               rdata_q;
  logic                           ready_d;
  logic                           ready_q;

  assign size = acc_size_e'(size_i);
  assign blk  = addr_i[ADDR_W-1:OFF_W];

  erb_lane_decode #(.BUS_BYTES(BUS_BYTES)) dec_i (
    .off_i      (addr_i[OFF_W-1:0]),
    .size_i     (size),
    .be_i       (be_i),
    .big_i      (big_endian_i),
    .aligned_o  (aligned),
    .win_phys_o (win_phys),
    .wr_phys_o  (wr_phys)
  );

  assign wr_en  = req_i & we_i & aligned;
  assign rd_hit = req_i & ~we_i & aligned;

  erb_reg_file #(.NUM_REGS(NUM_REGS), .REG_W(REG_W), .BUS_W(BUS_W)) rf_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en_i (wr_en),
    .blk_i   (blk),
    .big_i   (big_endian_i),
    .mask_i  (wr_phys),
    .wdata_i (wdata_i),
    .regs_o  (regs_q)
  );

  erb_read_steer #(.NUM_REGS(NUM_REGS), .REG_W(REG_W), .BUS_W(BUS_W)) rs_i (
    .regs_i  (regs_q),
    .blk_i   (blk),
    .big_i   (big_endian_i),
    .win_i   (win_phys),
    .rdata_o (steer_data)
  );

  always_comb begin
    rdata_d = rd_hit ? steer_data : '0;
    ready_d = req_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
      ready_q <= 1'b0;
    end else begin
      rdata_q <= rdata_d;
      ready_q <= ready_d;
    end
  end

  assign rdata_o = rdata_q;
  assign ready_o = ready_q;
endmodule

// File: rtl/erb_checker.sv
module erb_checker #(
  parameter int NUM_REGS = 8,
  parameter int REG_W    = 32,
  parameter int BUS_W    = 64,
  parameter int ADDR_W   = 5
) (
  input logic                           clk,
  input logic                           rst_n,
  input logic                           big_endian_i,
  input logic                           req_i,
  input logic                           we_i,
  input logic [ADDR_W-1:0]              addr_i,
  input logic [1:0]                     size_i,
  input logic [BUS_W-1:0]               rdata_o,
  input logic                           ready_o,
  input logic [NUM_REGS-1:0][REG_W-1:0] regs_i
);
  logic [3:0] span;
  logic       misaligned;

  assign span       = 4'd1 << size_i;
  assign misaligned = (({1'b0, addr_i[2:0]} & (span - 4'd1)) != 4'd0);

  // R7: a response follows every request, and only a request
  a_r7_ready_after_req: assert property (@(posedge clk) disable iff (!rst_n)
    req_i |=> ready_o);
  a_r7_no_spurious_ready: assert property (@(posedge clk) disable iff (!rst_n)
    !req_i |=> !ready_o);

  // R9: idle cycles and write responses carry zero data
  a_r9_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !req_i |=> (rdata_o == '0));
  a_r9_write_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i && we_i) |=> (rdata_o == '0));

  // R8: misaligned reads return zero, misaligned writes leave storage alone
  a_r8_misaligned_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i && !we_i && misaligned) |=> (rdata_o == '0));
  a_r8_misaligned_write_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i && we_i && misaligned) |=> $stable(regs_i));

  // R6: storage changes only on a write request
  a_r6_hold_without_write: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_i && we_i) |=> $stable(regs_i));

  // R10: mode stays put between request and response
  a_r10_mode_stable: assert property (@(posedge clk) disable iff (!rst_n)
    ready_o |-> $stable(big_endian_i));
endmodule

bind endian_reg_bank erb_checker #(
  .NUM_REGS(NUM_REGS), .REG_W(REG_W), .BUS_W(BUS_W), .ADDR_W(ADDR_W)
) chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .big_endian_i (big_endian_i),
  .req_i        (req_i),
  .we_i         (we_i),
  .addr_i       (addr_i),
  .size_i       (size_i),
  .rdata_o      (rdata_o),
  .ready_o      (ready_o),
  .regs_i       (regs_q)
);

// File: tb/endian_reg_bank_tb_top.sv
`timescale 1ns/1ps
module endian_reg_bank_tb_top;
  localparam real HALF = 2.5;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        big_endian_i = 1'b0;
  logic        req_i = 1'b0;
  logic        we_i = 1'b0;
  logic [4:0]  addr_i = '0;
  logic [1:0]  size_i = '0;
  logic [7:0]  be_i = '0;
  logic [63:0] wdata_i = '0;
  logic [63:0] rdata_o;
  logic        ready_o;

  int    n_chk = 0;
  int    n_bad = 0;
  bit    done = 0;
  string cur_tag = "R1 reset";

  logic [31:0] mreg [8];
  logic        exp_ready = 1'b0;
  logic [63:0] exp_rdata = '0;
  string       exp_tag = "R1 reset";

  always #(HALF) clk = ~clk;

  endian_reg_bank dut_i (
    .clk(clk), .rst_n(rst_n), .big_endian_i(big_endian_i), .req_i(req_i),
    .we_i(we_i), .addr_i(addr_i), .size_i(size_i), .be_i(be_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .ready_o(ready_o)
  );

  // Byte-addressed reference: byte address a belongs to register a/4, lane a%8.
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 8; i++) mreg[i] = 32'h0;
      exp_ready = 1'b0;
      exp_rdata = '0;
      exp_tag   = "R1 reset";
    end else begin
      exp_ready = req_i;
      exp_rdata = '0;
      exp_tag   = cur_tag;
      if (req_i) begin
        int off;
        int n;
        off = int'(addr_i) % 8;
        n   = 1 << size_i;
        if ((off % n) == 0) begin
          for (int i = 0; i < n; i++) begin
            int ba, lane, rg, rb, pos;
            ba   = int'(addr_i) + i;
            lane = ba % 8;
            rg   = ba / 4;
            rb   = big_endian_i ? 3 - (ba % 4) : ba % 4;
            pos  = big_endian_i ? (7 - lane) * 8 : lane * 8;
            if (we_i) begin
              if (be_i[lane]) mreg[rg][rb*8 +: 8] = wdata_i[pos +: 8];
            end else begin
              exp_rdata[pos +: 8] = mreg[rg][rb*8 +: 8];
            end
          end
        end
      end
    end
  end

  // Per-clock comparison against the model
  always @(negedge clk) begin
    if (!done) begin
      n_chk++;
      if (ready_o !== exp_ready || rdata_o !== exp_rdata) begin
        n_bad++;
        $display("FAIL %s (model): ready act=%b exp=%b rdata act=%h exp=%h",
                 exp_tag, ready_o, exp_ready, rdata_o, exp_rdata);
      end
    end
  end

  task automatic issue(input logic we, input logic [4:0] a, input logic [1:0] sz,
                       input logic [7:0] be, input logic [63:0] wd, input string tag);
    @(posedge clk); #1;
    req_i = 1'b1; we_i = we; addr_i = a; size_i = sz; be_i = be; wdata_i = wd;
    cur_tag = tag;
  endtask

  task automatic xfer(input logic we, input logic [4:0] a, input logic [1:0] sz,
                      input logic [7:0] be, input logic [63:0] wd, input string tag,
                      input logic [63:0] exp);
    issue(we, a, sz, be, wd, tag);
    @(posedge clk); #1;
    req_i = 1'b0;
    @(negedge clk);
    n_chk++;
    if (rdata_o !== exp || ready_o !== 1'b1) begin
      n_bad++;
      $display("FAIL %s: rdata act=%h exp=%h ready act=%b exp=1", tag, rdata_o, exp, ready_o);
    end
  endtask

  task automatic set_mode(input logic m);
    @(posedge clk); #1; req_i = 1'b0;
    @(posedge clk); #1; big_endian_i = m;
  endtask

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    n_chk++;
    if (ready_o !== 1'b0 || rdata_o !== 64'h0) begin
      n_bad++;
      $display("FAIL R1: in reset ready act=%b exp=0 rdata act=%h exp=0", ready_o, rdata_o);
    end
    @(posedge clk); #1; rst_n = 1'b1;

    // R1: all registers read zero after reset
    for (int b = 0; b < 4; b++)
      xfer(1'b0, 5'(b*8), 2'd3, 8'h00, '0, "R1 reset contents", 64'h0);

    // Little-endian
    xfer(1'b1, 5'd0, 2'd2, 8'h0F, 64'h0000_0000_1122_3344, "R9 write response", 64'h0);
    xfer(1'b0, 5'd0, 2'd2, 8'h00, '0, "R2 word LE", 64'h0000_0000_1122_3344);
    xfer(1'b0, 5'd0, 2'd0, 8'hFF, '0, "R5 byte0 LE", 64'h0000_0000_0000_0044);
    xfer(1'b0, 5'd2, 2'd1, 8'h00, '0, "R5 half2 LE", 64'h0000_0000_1122_0000);
    @(posedge clk); @(negedge clk);
    n_chk++;
    if (ready_o !== 1'b0) begin
      n_bad++;
      $display("FAIL R7: idle ready act=%b exp=0", ready_o);
    end

    // Big-endian
    set_mode(1'b1);
    xfer(1'b0, 5'd0, 2'd2, 8'h00, '0, "R10 word after mode change", 64'h1122_3344_0000_0000);
    xfer(1'b0, 5'd0, 2'd0, 8'h00, '0, "R5 byte0 BE", 64'h1100_0000_0000_0000);
    xfer(1'b0, 5'd3, 2'd0, 8'h00, '0, "R3 byte3 BE", 64'h0000_0044_0000_0000);
    xfer(1'b0, 5'd2, 2'd1, 8'h00, '0, "R5 half2 BE", 64'h0000_3344_0000_0000);
    xfer(1'b1, 5'd4, 2'd2, 8'hF0, 64'h0000_0000_AABB_CCDD, "R9 write response BE", 64'h0);
    xfer(1'b0, 5'd0, 2'd3, 8'h00, '0, "R4 dword BE", 64'h1122_3344_AABB_CCDD);
    xfer(1'b0, 5'd4, 2'd2, 8'h00, '0, "R2 word4 BE", 64'h0000_0000_AABB_CCDD);

    set_mode(1'b0);
    xfer(1'b0, 5'd0, 2'd3, 8'h00, '0, "R4 dword LE", 64'hAABB_CCDD_1122_3344);
    xfer(1'b0, 5'd4, 2'd2, 8'h00, '0, "R2 word4 LE", 64'hAABB_CCDD_0000_0000);

    // R6: byte-enable merge and window limit
    xfer(1'b1, 5'd0, 2'd2, 8'h05, 64'hFFFF_FFFF_FFFF_FFFF, "R6 partial be", 64'h0);
    xfer(1'b0, 5'd0, 2'd2, 8'hFF, '0, "R6 merged word", 64'h0000_0000_11FF_33FF);
    xfer(1'b1, 5'd0, 2'd0, 8'hFF, 64'h5A5A_5A5A_5A5A_5A5A, "R6 byte window", 64'h0);
    xfer(1'b0, 5'd0, 2'd2, 8'h00, '0, "R9 be ignored on read", 64'h0000_0000_11FF_335A);

    // R8: misaligned accesses
    xfer(1'b1, 5'd2, 2'd2, 8'hFF, 64'hFFFF_FFFF_FFFF_FFFF, "R8 misaligned write", 64'h0);
    xfer(1'b0, 5'd2, 2'd2, 8'h00, '0, "R8 misaligned read", 64'h0);
    xfer(1'b0, 5'd0, 2'd2, 8'h00, '0, "R8 no side effect", 64'h0000_0000_11FF_335A);
    xfer(1'b0, 5'd4, 2'd3, 8'h00, '0, "R8 misaligned dword", 64'h0);
    xfer(1'b0, 5'd1, 2'd1, 8'h00, '0, "R8 misaligned half", 64'h0);

    // R4: dword write in BE, then sub-word merge in BE
    set_mode(1'b1);
    xfer(1'b1, 5'd8, 2'd3, 8'hFF, 64'h0102_0304_0506_0708, "R4 dword write BE", 64'h0);
    xfer(1'b1, 5'd9, 2'd0, 8'h02, 64'h00EE_0000_0000_0000, "R6 byte write BE", 64'h0);
    xfer(1'b0, 5'd8, 2'd2, 8'h00, '0, "R6 merged BE", 64'h01EE_0304_0000_0000);
    set_mode(1'b0);
    xfer(1'b0, 5'd8, 2'd3, 8'h00, '0, "R4 pair LE", 64'h0506_0708_01EE_0304);
    xfer(1'b0, 5'd12, 2'd0, 8'h00, '0, "R3 byte12 LE", 64'h0000_0008_0000_0000);

    // Back-to-back random traffic, mode changes only between bursts
    for (int burst = 0; burst < 8; burst++) begin
      set_mode(1'(burst % 2));
      for (int i = 0; i < 100; i++) begin
        issue(1'($urandom % 2), 5'($urandom % 32), 2'($urandom % 4),
              8'($urandom), {$urandom, $urandom}, "R7 rand back-to-back");
      end
    end
    @(posedge clk); #1; req_i = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    done = 1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(HALF * 2.0 * 50000.0);
    if (!done) begin
      done = 1;
      n_bad++;
      $display("FAIL R7 watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule